// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog down-counter whose control registers can only be changed after an unlock key has been written. Software writes the 32-bit value 0xF1D0DEAD to a key register; that arms the unlock for exactly one following write to one of the guarded registers (the counter, the run enable or the interrupt-clear configuration). Any other write in between, or a guarded write that arrives unarmed, leaves the guarded state untouched. A dropped guarded write also raises a sticky violation flag.

While running, the counter steps down by one per clock and stops at zero. The step from one to zero raises a level timeout interrupt toward the interrupt combiner and a one-cycle reset request pulse. The interrupt stays pending until an authorised configuration write clears it. A typical shutdown is: key, load 0xFFFFFFFF, key, write 0 to the enable, key, clear the timeout interrupt.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the counter holds all ones, the watchdog is running, and the timeout pending, violation and armed flags are all clear; the interrupt and pulse outputs are low.
- R2: A write of 0xF1D0DEAD to address 0 (key) arms the unlock. The next write, if it goes to address 1 (count), 2 (enable, bit 0) or 3 (config, bit 0), takes effect and disarms.
- R3: A write to address 1, 2 or 3 while not armed is dropped and sets the violation flag, which stays set until reset.
- R4: A key write with any other value, or a write to address 4 or above, disarms the unlock without setting the violation flag.
- R5: One key write allows only one guarded write: a second guarded write right after it is dropped.
- R6: While enabled, the count falls by exactly one each clock. It stays at zero without wrapping. While disabled it holds its value.
- R7: When the enabled count steps from 1 to 0, the timeout pending flag and irq_timeout rise on that edge, and rst_pulse is high for exactly that one cycle.
- R8: An authorised config write with bit 0 = 0 clears the pending timeout. Bit 0 = 1 leaves it set. An expiry on the same edge wins over the clear.
- R9: An authorised count write loads the written value on that edge, overriding that cycle's decrement.
- R10: bus_rdata is combinational from bus_addr: address 0 reads 0; address 1 reads the count; address 2 reads the enable in bit 0; address 3 reads the pending flag in bit 0; address 4 reads {enabled, armed, violation, pending} in bits 3..0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_timeout | output | 1 | Level timeout interrupt to the combiner |
| rst_pulse | output | 1 | One-cycle pulse on expiry |

## Verification
The bench drives several write patterns: guarded writes with no key, key followed directly by a guarded write, key followed by an unrelated write, a wrong key value, and two guarded writes after one key. Between them, these separate a correct one-shot arm from a sticky arm, from an arm that survives other writes, and from one that ignores the key value. Countdown runs to expiry from small loaded values show the exact expiry edge, the saturation at zero and the hold while disabled. One run lines up a clear with the expiry edge to show that expiry takes priority.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY    = 3'd0,
    A_COUNT  = 3'd1,
    A_ENABLE = 3'd2,
    A_CONFIG = 3'd3,
    A_STATUS = 3'd4
  } wdg_addr_e;

  // Addresses whose writes need a preceding key write.
  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == A_COUNT) || (a == A_ENABLE) || (a == A_CONFIG);
  endfunction
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
  import wdg_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'hF1D0DEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              violation,
  output logic              grant
);
  logic key_hit, guarded_wr, denied;

  assign key_hit    = wr && (addr == A_KEY) && (wdata == DATA_W'(KEY));
  assign guarded_wr = wr && is_guarded(addr);
  assign grant      = guarded_wr && armed;
  assign denied     = guarded_wr && !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      violation <= 1'b0;
    end else begin
      if (key_hit)  armed <= 1'b1;
      else if (wr)  armed <= 1'b0;
      if (denied)   violation <= 1'b1;
    end
  end

  p_key_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> armed);
  p_deny_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    denied |=> violation);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !key_hit) |=> !armed);
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int   CNT_W     = 32,
  parameter logic RESET_RUN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en_wr,
  input  logic             en_val,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Saturating step: never goes below zero.
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic run);
    return (run && c != '0) ? c - ONE : c;
  endfunction

  assign expire = enabled && (count == ONE) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '1;
      enabled <= RESET_RUN;
    end else begin
      count <= load ? load_val : step(count, enabled);
      if (en_wr) enabled <= en_val;
    end
  end

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |=> count == '0);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && count != '0 && !load) |=> count == $past(count) - ONE);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !load) |=> $stable(count));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/wdg_irq.sv
module wdg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear,
  output logic pending,
  output logic rst_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= expire;
      if (expire)     pending <= 1'b1;
      else if (clear) pending <= 1'b0;
    end
  end

  p_expire_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pending && rst_pulse));
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !expire) |=> !pending);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !expire) |=> !pending);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] KEY       = 32'hF1D0DEAD,
  parameter logic        RESET_RUN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_timeout,
  output logic              rst_pulse
);
  logic             armed, violation, grant;
  logic             load, en_wr, clear, expire, enabled, pending;
  logic [CNT_W-1:0] count;

  wdg_unlock #(.DATA_W(DATA_W), .KEY(KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .armed(armed), .violation(violation), .grant(grant)
  );

  assign load  = grant && (bus_addr == A_COUNT);
  assign en_wr = grant && (bus_addr == A_ENABLE);
  assign clear = grant && (bus_addr == A_CONFIG) && !bus_wdata[0];

  wdg_down_counter #(.CNT_W(CNT_W), .RESET_RUN(RESET_RUN)) u_counter (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(bus_wdata[CNT_W-1:0]),
    .en_wr(en_wr), .en_val(bus_wdata[0]),
    .count(count), .enabled(enabled), .expire(expire)
  );

  wdg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clear(clear),
    .pending(pending), .rst_pulse(rst_pulse)
  );

  assign irq_timeout = pending;

  always_comb begin
    case (bus_addr)
      A_COUNT:  bus_rdata = DATA_W'(count);
      A_ENABLE: bus_rdata = DATA_W'(enabled);
      A_CONFIG: bus_rdata = DATA_W'(pending);
      A_STATUS: bus_rdata = DATA_W'({enabled, armed, violation, pending});
      default:  bus_rdata = '0;
    endcase
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> irq_timeout);
  p_denied_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_COUNT && !armed && enabled && count != '0)
      |=> count == $past(count) - CNT_W'(1));
endmodule

// File: tb/wdg_keyed_top_test.sv
module wdg_keyed_top_test;
  localparam logic [31:0] KEY = 32'hF1D0DEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_timeout, rst_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdg_keyed_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_timeout(irq_timeout), .rst_pulse(rst_pulse)
  );

  // Behavioural reference model
  logic [31:0] m_cnt   = 32'hFFFFFFFF;
  bit          m_en    = 1;
  bit          m_pend  = 0;
  bit          m_pulse = 0;
  bit          m_armed = 0;
  bit          m_viol  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 32'hFFFFFFFF; m_en = 1; m_pend = 0; m_pulse = 0; m_armed = 0; m_viol = 0;
    end else begin
      bit guarded, ok, exp_now, old_en;
      guarded = bus_wr && (bus_addr >= 3'd1) && (bus_addr <= 3'd3);
      ok      = guarded && m_armed;
      old_en  = m_en;
      if (guarded && !m_armed) m_viol = 1;
      exp_now = old_en && (m_cnt == 1) && !(ok && bus_addr == 3'd1);
      if (ok && bus_addr == 3'd1)      m_cnt = bus_wdata;
      else if (old_en && m_cnt != 0)   m_cnt = m_cnt - 1;
      if (ok && bus_addr == 3'd2)      m_en = bus_wdata[0];
      if (exp_now)                     m_pend = 1;
      else if (ok && bus_addr == 3'd3 && !bus_wdata[0]) m_pend = 0;
      m_pulse = exp_now;
      if (bus_wr) m_armed = (bus_addr == 3'd0) && (bus_wdata == KEY);
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd1: return m_cnt;
      3'd2: return {31'd0, m_en};
      3'd3: return {31'd0, m_pend};
      3'd4: return {28'd0, m_en, m_armed, m_viol, m_pend};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle compare, away from the active edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk("R7 irq_timeout vs model", {31'd0, irq_timeout}, {31'd0, m_pend});
      chk("R7 rst_pulse vs model", {31'd0, rst_pulse}, {31'd0, m_pulse});
      chk("R10 bus_rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #2;
    v = bus_rdata;
  endtask

  task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset status: only enabled
    peek(3'd4, 32'h8, "R1 status after reset");
    rd(3'd1, c0);
    chk("R1 count near all ones", {31'd0, c0 > 32'hFFFF0000}, 32'd1);

    // R3: unkeyed count write dropped, violation set
    wr(3'd1, 32'd5);
    peek(3'd4, 32'hA, "R3 violation after unkeyed write");
    rd(3'd1, c0);
    chk("R3 count untouched", {31'd0, c0 > 32'd1000}, 32'd1);

    // R2/R6/R7: keyed load, count to expiry, saturate
    wr(3'd0, KEY);
    wr(3'd1, 32'd6);
    idle(10);
    peek(3'd1, 32'd0, "R6 count saturates at zero");
    peek(3'd4, 32'hB, "R7 pending after expiry");

    // R3: unkeyed clear dropped
    wr(3'd3, 32'd0);
    peek(3'd4, 32'hB, "R3 unkeyed clear dropped");

    // R8: config bit0=1 keeps, bit0=0 clears
    wr(3'd0, KEY);
    wr(3'd3, 32'd1);
    peek(3'd4, 32'hB, "R8 config bit0=1 keeps pending");
    wr(3'd0, KEY);
    wr(3'd3, 32'd0);
    peek(3'd4, 32'hA, "R8 clear pending");

    // R4: write to status between key and count disarms
    wr(3'd0, KEY);
    wr(3'd4, 32'd0);
    wr(3'd1, 32'd9);
    peek(3'd1, 32'd0, "R4 intervening write disarms");
    // R4: wrong key
    wr(3'd0, 32'h12345678);
    wr(3'd1, 32'd9);
    peek(3'd1, 32'd0, "R4 wrong key does not arm");

    // R9: keyed load overrides decrement
    wr(3'd0, KEY);
    wr(3'd1, 32'd50);
    peek(3'd1, 32'd50, "R9 load value wins");
    // R5: second guarded write after one key
    wr(3'd0, KEY);
    wr(3'd1, 32'd80);
    wr(3'd2, 32'd0);
    peek(3'd1, 32'd79, "R5 count after single keyed load");
    peek(3'd4, 32'hA, "R5 second write dropped, still enabled");

    // R6: disabled holds
    wr(3'd0, KEY);
    wr(3'd2, 32'd0);
    peek(3'd4, 32'h2, "R2 enable cleared by keyed write");
    rd(3'd1, c0);
    idle(5);
    rd(3'd1, c1);
    chk("R6 disabled count holds", c1, c0);

    // R7: re-enable with count 1 expires next edge
    wr(3'd0, KEY);
    wr(3'd1, 32'd1);
    wr(3'd0, KEY);
    wr(3'd2, 32'd1);
    idle(2);
    peek(3'd4, 32'hB, "R7 expiry after re-enable");

    // R8: clear on the expiry edge loses
    wr(3'd0, KEY);
    wr(3'd3, 32'd0);
    peek(3'd4, 32'hA, "R8 cleared before race");
    wr(3'd0, KEY);
    wr(3'd1, 32'd3);
    idle(1);
    wr(3'd0, KEY);
    wr(3'd3, 32'd0);
    peek(3'd4, 32'hB, "R8 expiry wins over same-edge clear");
    peek(3'd0, 32'd0, "R10 key address reads zero");
    peek(3'd7, 32'd0, "R10 unmapped address reads zero");

    idle(3);
    finish_up();
  end
endmodule